// File: doc/BRIEF.md
# Per-Channel Transmit Descriptor Ring Walker

This block walks per-channel rings of transmit buffer descriptors for a cell segmenter. A scheduler hands it one channel number at a time. The block looks up that channel's current descriptor in a small local descriptor store. If the descriptor is ready, the block emits exactly one 48-byte cell payload as a stream of byte addresses taken from the referenced buffer. It then updates the channel's connection-table entry and signals completion, so that the scheduler can move on to the next channel in its queue. Cells from different channels therefore interleave freely.

Each channel keeps a ring base, a current descriptor index, a running data pointer, a remaining-byte count and an in-progress flag. A buffer longer than one cell is sent over several services of the channel. The descriptor index stays put between those services, and the data pointer carries the position forward. When a buffer runs out, the block clears the descriptor's ready flag and writes it back. The descriptor index then steps to the next entry, or returns to the ring base if the exhausted descriptor carries the wrap flag. Bytes of a cell that lie past the end of the buffer are flagged as padding.

Descriptors are loaded through a simple write port. Each channel's ring base is set through a second write port, which also resets the channel to the start of its ring. Descriptor bit layout: bit 50 ready, bit 49 wrap, bit 48 last-in-frame, bits 47:32 byte length, bits 31:0 buffer byte address.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset, busy, done, sent, eof and cell_valid are all low.
- R2: A service request (svc_valid high while idle) whose current descriptor has bit 50 set produces exactly 48 consecutive cell_valid beats while busy is high, then a single-cycle done pulse with sent high.
- R3: The first cell taken from a descriptor starts at that descriptor's buffer address (bits 31:0), and each following beat's cell_addr is one more than the previous beat's.
- R4: While a buffer still holds unsent bytes after a cell, the channel stays on the same descriptor, and its next cell starts 48 bytes after the previous cell's start.
- R5: When a cell consumes the last bytes of a buffer, that descriptor's ready bit is cleared in the store, and the channel moves to the next descriptor index.
- R6: When the exhausted descriptor has its wrap bit (bit 49) set, the channel's descriptor index returns to the channel's ring base rather than incrementing.
- R7: A service whose current descriptor has its ready bit clear emits no beats, gives done with sent low, and leaves the channel's state unchanged.
- R8: A beat whose offset within the cell is at or beyond the buffer's remaining byte count has cell_pad high; all earlier beats have cell_pad low.
- R9: eof is high with done exactly when the cell exhausted a buffer whose last-in-frame bit (bit 48) is set.
- R10: Each channel's position is kept independently, so serving other channels between two services of a channel does not disturb it.
- R11: svc_valid is ignored while busy; a request raised during a cell does not start a second service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_valid | input | 1 | Service request from the scheduler |
| svc_chan | input | 4 | Channel to serve |
| busy | output | 1 | A service is in progress |
| done | output | 1 | One-cycle completion pulse |
| sent | output | 1 | With done: a cell was sent |
| eof | output | 1 | With done: the cell ended a frame |
| cell_valid | output | 1 | A payload byte beat is presented |
| cell_addr | output | 32 | Byte address of the current beat |
| cell_pad | output | 1 | Current beat is padding |
| dm_we | input | 1 | Descriptor store write enable |
| dm_idx | input | 4 | Descriptor store write index |
| dm_wdata | input | 51 | Descriptor word to write |
| ct_we | input | 1 | Channel ring base write enable |
| ct_chan | input | 4 | Channel whose ring base is written |
| ct_base | input | 4 | Ring base descriptor index |

## Verification
The bench targets the transitions between descriptors. It checks the continuation cell, which a design that advanced on every cell would take from the wrong buffer. It checks the short tail cell, where a wrong remaining count shifts the number of pad beats. It checks the wrap descriptor, which a design that incremented past it would leave pointing outside the ring. It also revisits an exhausted descriptor: a design that failed to write back the cleared ready bit would send stale data, and one that advanced on a skipped descriptor would lose its place. Interleaved channels and a request raised in mid-cell catch shared position state and a design that accepts work while busy.

// File: rtl/txd_ring_pkg.sv
package txd_ring_pkg;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;

   typedef struct packed {
      logic              ready;
      logic              wrap;
      logic              last;
      logic [LEN_W-1:0]  len;
      logic [ADDR_W-1:0] addr;
   } desc_t;

   localparam int DESC_W = $bits(desc_t);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_SEND = 2'd2,
      ST_FIN  = 2'd3
   } walk_st_t;
endpackage

// File: rtl/txd_desc_store.sv
module txd_desc_store
   import txd_ring_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output desc_t            rd_desc,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_idx,
   input  desc_t            cfg_desc,
   input  logic             wb_we,
   input  logic [IDX_W-1:0] wb_idx,
   input  desc_t            wb_desc
);
   desc_t ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent[i] <= '0;
         else if (wb_we && wb_idx == IDX_W'(i))
            ent[i] <= wb_desc;
         else if (cfg_we && cfg_idx == IDX_W'(i))
            ent[i] <= cfg_desc;
      end
   end

   assign rd_desc = ent[rd_idx];
endmodule

// File: rtl/txd_chan_table.sv
module txd_chan_table
   import txd_ring_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int DEPTH  = 16,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   rd_chan,
   output logic [IDX_W-1:0]  rd_base,
   output logic [IDX_W-1:0]  rd_dptr,
   output logic [ADDR_W-1:0] rd_ptr,
   output logic [LEN_W-1:0]  rd_rem,
   output logic              rd_act,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_chan,
   input  logic [IDX_W-1:0]  cfg_base,
   input  logic              upd_we,
   input  logic [IDX_W-1:0]  upd_dptr,
   input  logic [ADDR_W-1:0] upd_ptr,
   input  logic [LEN_W-1:0]  upd_rem,
   input  logic              upd_act
);
   logic [IDX_W-1:0]  base_r [NUM_CH];
   logic [IDX_W-1:0]  dptr_r [NUM_CH];
   logic [ADDR_W-1:0] ptr_r  [NUM_CH];
   logic [LEN_W-1:0]  rem_r  [NUM_CH];
   logic              act_r  [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_r[c] <= '0;
            dptr_r[c] <= '0;
            ptr_r[c]  <= '0;
            rem_r[c]  <= '0;
            act_r[c]  <= 1'b0;
         end else if (cfg_we && cfg_chan == CH_W'(c)) begin
            base_r[c] <= cfg_base;
            dptr_r[c] <= cfg_base;
            act_r[c]  <= 1'b0;
         end else if (upd_we && rd_chan == CH_W'(c)) begin
            dptr_r[c] <= upd_dptr;
            ptr_r[c]  <= upd_ptr;
            rem_r[c]  <= upd_rem;
            act_r[c]  <= upd_act;
         end
      end
   end

   assign rd_base = base_r[rd_chan];
   assign rd_dptr = dptr_r[rd_chan];
   assign rd_ptr  = ptr_r[rd_chan];
   assign rd_rem  = rem_r[rd_chan];
   assign rd_act  = act_r[rd_chan];
endmodule

// File: rtl/txd_cell_seq.sv
module txd_cell_seq
   import txd_ring_pkg::*;
#(
   parameter int NUM_CH     = 16,
   parameter int DEPTH      = 16,
   parameter int CELL_BYTES = 48,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int IDX_W = $clog2(DEPTH),
   localparam int BT_W  = $clog2(CELL_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              svc_valid,
   input  logic [CH_W-1:0]   svc_chan,
   output logic              busy,
   output logic              done,
   output logic              sent,
   output logic              eof,
   output logic              cell_valid,
   output logic [ADDR_W-1:0] cell_addr,
   output logic              cell_pad,
   output logic [CH_W-1:0]   chan,
   input  logic [IDX_W-1:0]  ch_base,
   input  logic [IDX_W-1:0]  ch_dptr,
   input  logic [ADDR_W-1:0] ch_ptr,
   input  logic [LEN_W-1:0]  ch_rem,
   input  logic              ch_act,
   output logic              upd_we,
   output logic [IDX_W-1:0]  upd_dptr,
   output logic [ADDR_W-1:0] upd_ptr,
   output logic [LEN_W-1:0]  upd_rem,
   output logic              upd_act,
   input  desc_t             rd_desc,
   output logic              wb_we,
   output desc_t             wb_desc
);
   localparam logic [BT_W-1:0]   LAST_BEAT = BT_W'(CELL_BYTES - 1);
   localparam logic [LEN_W-1:0]  CELL_LEN  = LEN_W'(CELL_BYTES);
   localparam logic [ADDR_W-1:0] CELL_ADV  = ADDR_W'(CELL_BYTES);

   walk_st_t          st;
   desc_t             d_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [LEN_W-1:0]  rem_q;
   logic [BT_W-1:0]   beat_q;
   logic              done_q, sent_q, eof_q;
   logic [LEN_W-1:0]  used, left;
   logic              drained;

   always_comb begin
      used    = (rem_q > CELL_LEN) ? CELL_LEN : rem_q;
      left    = rem_q - used;
      drained = (left == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         chan   <= '0;
         d_q    <= '0;
         ptr_q  <= '0;
         rem_q  <= '0;
         beat_q <= '0;
         done_q <= 1'b0;
         sent_q <= 1'b0;
         eof_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: if (svc_valid) begin
               chan <= svc_chan;
               st   <= ST_LOAD;
            end
            ST_LOAD: if (!rd_desc.ready) begin
               done_q <= 1'b1;
               sent_q <= 1'b0;
               eof_q  <= 1'b0;
               st     <= ST_IDLE;
            end else begin
               d_q    <= rd_desc;
               ptr_q  <= ch_act ? ch_ptr : rd_desc.addr;
               rem_q  <= ch_act ? ch_rem : rd_desc.len;
               beat_q <= '0;
               st     <= ST_SEND;
            end
            ST_SEND: begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == LAST_BEAT) st <= ST_FIN;
            end
            default: begin
               done_q <= 1'b1;
               sent_q <= 1'b1;
               eof_q  <= drained & d_q.last;
               st     <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy       = (st != ST_IDLE);
   assign done       = done_q;
   assign sent       = done_q & sent_q;
   assign eof        = done_q & eof_q;
   assign cell_valid = (st == ST_SEND);
   assign cell_addr  = ptr_q + ADDR_W'(beat_q);
   assign cell_pad   = cell_valid & (LEN_W'(beat_q) >= rem_q);

   assign upd_we   = (st == ST_FIN);
   assign upd_act  = !drained;
   assign upd_ptr  = ptr_q + CELL_ADV;
   assign upd_rem  = left;
   assign upd_dptr = !drained ? ch_dptr : (d_q.wrap ? ch_base : ch_dptr + 1'b1);

   assign wb_we   = (st == ST_FIN) & drained;
   always_comb begin
      wb_desc       = d_q;
      wb_desc.ready = 1'b0;
   end
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
   import txd_ring_pkg::*;
#(
   parameter int NUM_CH     = 16,
   parameter int DESC_DEPTH = 16,
   parameter int CELL_BYTES = 48,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int IDX_W = $clog2(DESC_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              svc_valid,
   input  logic [CH_W-1:0]   svc_chan,
   output logic              busy,
   output logic              done,
   output logic              sent,
   output logic              eof,
   output logic              cell_valid,
   output logic [ADDR_W-1:0] cell_addr,
   output logic              cell_pad,
   input  logic              dm_we,
   input  logic [IDX_W-1:0]  dm_idx,
   input  logic [DESC_W-1:0] dm_wdata,
   input  logic              ct_we,
   input  logic [CH_W-1:0]   ct_chan,
   input  logic [IDX_W-1:0]  ct_base
);
   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (DESC_DEPTH < 2 || (DESC_DEPTH & (DESC_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DESC_DEPTH must be a power of two of at least 2");
   end
   if (CELL_BYTES < 2 || CELL_BYTES >= (1 << LEN_W)) begin : g_bad_cell
      $error("CELL_BYTES out of range");
   end

   logic [CH_W-1:0]   chan;
   logic [IDX_W-1:0]  ch_base, ch_dptr, upd_dptr;
   logic [ADDR_W-1:0] ch_ptr, upd_ptr;
   logic [LEN_W-1:0]  ch_rem, upd_rem;
   logic              ch_act, upd_we, upd_act, wb_we;
   desc_t             rd_desc, wb_desc;

   txd_desc_store #(.DEPTH(DESC_DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ch_dptr), .rd_desc(rd_desc),
      .cfg_we(dm_we), .cfg_idx(dm_idx), .cfg_desc(desc_t'(dm_wdata)),
      .wb_we(wb_we), .wb_idx(ch_dptr), .wb_desc(wb_desc)
   );

   txd_chan_table #(.NUM_CH(NUM_CH), .DEPTH(DESC_DEPTH)) u_table (
      .clk(clk), .rst_n(rst_n),
      .rd_chan(chan), .rd_base(ch_base), .rd_dptr(ch_dptr),
      .rd_ptr(ch_ptr), .rd_rem(ch_rem), .rd_act(ch_act),
      .cfg_we(ct_we), .cfg_chan(ct_chan), .cfg_base(ct_base),
      .upd_we(upd_we), .upd_dptr(upd_dptr), .upd_ptr(upd_ptr),
      .upd_rem(upd_rem), .upd_act(upd_act)
   );

   txd_cell_seq #(.NUM_CH(NUM_CH), .DEPTH(DESC_DEPTH), .CELL_BYTES(CELL_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .svc_valid(svc_valid), .svc_chan(svc_chan),
      .busy(busy), .done(done), .sent(sent), .eof(eof),
      .cell_valid(cell_valid), .cell_addr(cell_addr), .cell_pad(cell_pad),
      .chan(chan),
      .ch_base(ch_base), .ch_dptr(ch_dptr), .ch_ptr(ch_ptr),
      .ch_rem(ch_rem), .ch_act(ch_act),
      .upd_we(upd_we), .upd_dptr(upd_dptr), .upd_ptr(upd_ptr),
      .upd_rem(upd_rem), .upd_act(upd_act),
      .rd_desc(rd_desc), .wb_we(wb_we), .wb_desc(wb_desc)
   );
endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk #(
   parameter int CELL_BYTES = 48,
   localparam int CNT_W = $clog2(CELL_BYTES + 2)
) (
   input logic        clk,
   input logic        rst_n,
   input logic        svc_valid,
   input logic        busy,
   input logic        done,
   input logic        sent,
   input logic        eof,
   input logic        cell_valid,
   input logic [31:0] cell_addr,
   input logic        cell_pad
);
   logic [CNT_W-1:0] beats;

   always_ff @(posedge clk) begin
      if (!rst_n)         beats <= '0;
      else if (done)      beats <= '0;
      else if (cell_valid) beats <= beats + 1'b1;
   end

   p_beat_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cell_valid |-> busy);
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_full_cell_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sent) |-> (beats == CNT_W'(CELL_BYTES)));
   p_skip_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !sent) |-> (beats == '0));
   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_valid && $past(cell_valid)) |-> (cell_addr == $past(cell_addr) + 32'd1));
   p_pad_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_valid && $past(cell_valid) && $past(cell_pad)) |-> cell_pad);
   p_eof_with_cell_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> (done && sent));
   p_start_on_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(svc_valid));
endmodule

bind txd_ring_walker txd_ring_walker_chk #(.CELL_BYTES(CELL_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .svc_valid(svc_valid), .busy(busy),
   .done(done), .sent(sent), .eof(eof), .cell_valid(cell_valid),
   .cell_addr(cell_addr), .cell_pad(cell_pad)
);

// File: tb/txd_ring_walker_bench.sv
module txd_ring_walker_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        svc_valid = 1'b0;
   logic [3:0]  svc_chan = '0;
   logic        busy, done, sent, eof, cell_valid, cell_pad;
   logic [31:0] cell_addr;
   logic        dm_we = 1'b0;
   logic [3:0]  dm_idx = '0;
   logic [50:0] dm_wdata = '0;
   logic        ct_we = 1'b0;
   logic [3:0]  ct_chan = '0;
   logic [3:0]  ct_base = '0;

   int total = 0;
   int bad = 0;

   int          r_beats, r_pads;
   logic [31:0] r_first;
   logic        r_sent, r_eof;

   always #(CLK_P/2) clk = ~clk;

   txd_ring_walker u_txd_ring_walker (
      .clk(clk), .rst_n(rst_n), .svc_valid(svc_valid), .svc_chan(svc_chan),
      .busy(busy), .done(done), .sent(sent), .eof(eof),
      .cell_valid(cell_valid), .cell_addr(cell_addr), .cell_pad(cell_pad),
      .dm_we(dm_we), .dm_idx(dm_idx), .dm_wdata(dm_wdata),
      .ct_we(ct_we), .ct_chan(ct_chan), .ct_base(ct_base)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [50:0] mk(input logic r, input logic w, input logic l,
                                      input logic [15:0] len, input logic [31:0] a);
      return {r, w, l, len, a};
   endfunction

   task automatic put_desc(input int idx, input logic [50:0] d);
      @(negedge clk);
      dm_we = 1'b1; dm_idx = 4'(idx); dm_wdata = d;
      @(negedge clk);
      dm_we = 1'b0;
   endtask

   task automatic put_base(input int ch, input int base);
      @(negedge clk);
      ct_we = 1'b1; ct_chan = 4'(ch); ct_base = 4'(base);
      @(negedge clk);
      ct_we = 1'b0;
   endtask

   // poke_at >= 0 raises a second request on that beat of the cell
   task automatic serve(input int ch, input int poke_at);
      bit got = 0;
      int guard = 0;
      r_beats = 0; r_pads = 0; r_first = '0; r_sent = 0; r_eof = 0;
      @(negedge clk);
      svc_valid = 1'b1; svc_chan = 4'(ch);
      @(negedge clk);
      svc_valid = 1'b0;
      while (!got && guard < 200) begin
         if (cell_valid) begin
            if (r_beats == 0) r_first = cell_addr;
            if (r_beats == poke_at) begin svc_valid = 1'b1; svc_chan = 4'd2; end
            else svc_valid = 1'b0;
            r_beats++;
            if (cell_pad) r_pads++;
         end
         if (done) begin got = 1; r_sent = sent; r_eof = eof; end
         else @(negedge clk);
         guard++;
      end
      svc_valid = 1'b0;
      if (!got) chk("R2 watchdog done", 32'd0, 32'd1);
   endtask

   task automatic t_reset;
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 sent", sent, 0);
      chk("R1 eof", eof, 0);
      chk("R1 cell_valid", cell_valid, 0);
   endtask

   task automatic t_first_cell;
      serve(1, -1);
      chk("R2 beats", r_beats, 48);
      chk("R2 sent", r_sent, 1);
      chk("R3 first addr", r_first, 32'h1000);
      chk("R8 no pad full buffer", r_pads, 0);
      chk("R9 eof mid buffer", r_eof, 0);
   endtask

   task automatic t_interleave;
      serve(2, -1);
      chk("R10 ch2 addr", r_first, 32'h3000);
      chk("R9 eof exact cell", r_eof, 1);
      chk("R8 no pad exact", r_pads, 0);
      serve(1, -1);
      chk("R4 continuation addr", r_first, 32'h1030);
      chk("R10 ch1 kept", r_pads, 0);
   endtask

   task automatic t_tail_and_wrap;
      serve(1, -1);
      chk("R4 third cell addr", r_first, 32'h1060);
      chk("R8 pad count tail", r_pads, 44);
      chk("R9 no eof not last", r_eof, 0);
      serve(1, -1);
      chk("R5 advanced to next desc", r_first, 32'h2000);
      chk("R8 pad count short", r_pads, 28);
      chk("R9 eof last", r_eof, 1);
      serve(1, -1);
      chk("R5 cleared desc skipped", r_sent, 0);
      chk("R7 skip no beats", r_beats, 0);
      put_desc(0, mk(1, 0, 1, 16'd48, 32'h5000));
      serve(1, -1);
      chk("R6 wrapped to base", r_first, 32'h5000);
   endtask

   task automatic t_not_ready;
      serve(2, -1);
      chk("R7 skip sent", r_sent, 0);
      chk("R7 skip eof", r_eof, 0);
      put_desc(5, mk(1, 0, 1, 16'd4, 32'h7000));
      serve(2, -1);
      chk("R7 state unchanged after skip", r_first, 32'h7000);
      chk("R8 pads small", r_pads, 44);
   endtask

   task automatic t_busy_ignore;
      bit extra = 0;
      serve(3, 10);
      chk("R6 single ring addr", r_first, 32'h4000);
      chk("R8 pads len10", r_pads, 38);
      repeat (60) begin
         @(negedge clk);
         if (busy || done) extra = 1;
      end
      chk("R11 request while busy ignored", extra, 0);
      put_desc(8, mk(1, 1, 0, 16'd60, 32'h6000));
      serve(3, -1);
      chk("R6 one-entry ring wraps", r_first, 32'h6000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      put_base(1, 0);
      put_base(2, 4);
      put_base(3, 8);
      put_desc(0, mk(1, 0, 0, 16'd100, 32'h1000));
      put_desc(1, mk(1, 1, 1, 16'd20, 32'h2000));
      put_desc(4, mk(1, 0, 1, 16'd48, 32'h3000));
      put_desc(5, mk(0, 0, 0, 16'd48, 32'h3100));
      put_desc(8, mk(1, 1, 1, 16'd10, 32'h4000));
      t_first_cell();
      t_interleave();
      t_tail_and_wrap();
      t_not_ready();
      t_busy_ignore();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule